// File: doc/BRIEF.md
# Programmable Logic Output Cell Bank

This block models the output stage of a sum-of-products programmable logic device. It holds a parameterised number of output cells, each fed by one sum-of-products result, one private output-enable product term and two configuration bits. One bit chooses registered or combinational operation. The other chooses the output polarity, active-high or active-low. All cells share one synchronous-set term and one asynchronous-clear term, as the registers of such a device do.

Each cell drives a pad model made of a data value and an enable. It also returns a feedback value to the logic array. A registered cell feeds back the complement of its register. A combinational cell feeds back the level on its pad, so a cell whose enable term is low turns its pin into an extra input. For test, a preload strobe writes any chosen value into every register on a clock edge. The chip reset stands in for power-up clear. It is asserted asynchronously and released through a synchroniser.

Top module: `pal_macrocell_bank`

## Requirements
- R1: While `rst_ni` is low, every register is 0. A registered active-high cell drives `pin_o` low, and a registered active-low cell drives it high.
- R2: For a registered cell with no clear, preload or set, `pin_o` after a rising edge equals the `sum_i` bit sampled at that edge. The value is inverted when `cfg_act_high_i` is 0.
- R3: For a combinational cell, `pin_o` follows `sum_i` in the same cycle. It is inverted when `cfg_act_high_i` is 0.
- R4: When `sset_i` is 1 at a rising edge, and neither clear nor preload is active, the register loads 1. A registered cell then drives 1 if active-high and 0 if active-low, whatever `sum_i` holds.
- R5: While `areset_i` is 1, the register is 0 at once, with no clock edge needed, including when it rises mid-cycle. Clear overrides preload and set.
- R6: When `preload_en_i` is 1 at a rising edge and clear is inactive, each register loads its `preload_val_i` bit. Preload overrides set and `sum_i`.
- R7: `pin_oe_o` of each cell equals its `oe_term_i` bit, with 1 meaning the pin is driven. Neither the mode nor the polarity changes it.
- R8: A registered cell's `fb_o` is the complement of its register, whatever `oe_term_i` holds.
- R9: A combinational cell's `fb_o` equals its own `pin_o` when `oe_term_i` is 1, and equals `pin_ext_i` when it is 0.
- R10: `sset_i` and `areset_i` act on the registers of all cells at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low power-up clear, asynchronous assert, synchronised release |
| cfg_reg_mode_i | input | CELLS | Per cell: 1 registered, 0 combinational |
| cfg_act_high_i | input | CELLS | Per cell: 1 non-inverting output, 0 inverting |
| sum_i | input | CELLS | Sum-of-products result for each cell |
| oe_term_i | input | CELLS | Output-enable product term for each cell |
| pin_ext_i | input | CELLS | Level driven onto each pin from outside when not enabled |
| sset_i | input | 1 | Shared synchronous-set term |
| areset_i | input | 1 | Shared asynchronous-clear term |
| preload_en_i | input | 1 | Test preload strobe |
| preload_val_i | input | CELLS | Value preloaded into each register |
| pin_o | output | CELLS | Pin data value after mode and polarity selection |
| pin_oe_o | output | CELLS | Pin drive enable |
| fb_o | output | CELLS | Feedback value to the logic array |

## Verification
The bench raises the clear term halfway through a cycle, after a set has loaded the registers. A design that only samples the clear on the clock would show the set level for the rest of that cycle. It drives preload and set together, and preload then a plain clock edge. A reversed priority or a preload that sticks would leave the wrong register value. It runs all four mode and polarity pairs at once. A polarity applied to the wrong path, or a power-up level that ignores polarity, would make one of the pairs mismatch. It also disables combinational cells while driving their pins from outside, so feedback taken from the internal value instead of the pad would be caught.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

  typedef enum logic [1:0] {
    LOAD_DATA    = 2'd0,
    LOAD_SET     = 2'd1,
    LOAD_PRELOAD = 2'd2
  } pal_load_e;

endpackage

// File: rtl/pal_mc_rst_sync.sv
module pal_mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[STAGES-1];

endmodule

// File: rtl/pal_mc_cell_reg.sv
module pal_mc_cell_reg
  import pal_mc_pkg::*;
(
  input  logic clk_i,
  input  logic clr_ni,
  input  logic sum_i,
  input  logic sset_i,
  input  logic preload_en_i,
  input  logic preload_val_i,
  output logic q_o
);

  pal_load_e sel;
  logic      q_d;
  logic      q_q;

  // preload beats set, set beats the array data
  always_comb begin
    if (preload_en_i) begin
      sel = LOAD_PRELOAD;
    end else if (sset_i) begin
      sel = LOAD_SET;
    end else begin
      sel = LOAD_DATA;
    end
  end

  always_comb begin
    unique case (sel)
      LOAD_PRELOAD: q_d = preload_val_i;
      LOAD_SET:     q_d = 1'b1;
      default:      q_d = sum_i;
    endcase
  end

  // clear input combines power-up clear and the shared clear term
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/pal_mc_cell_out.sv
module pal_mc_cell_out (
  input  logic reg_mode_i,
  input  logic act_high_i,
  input  logic q_i,
  input  logic sum_i,
  input  logic oe_term_i,
  input  logic pin_ext_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic fb_o
);

  logic core_val;
  logic pad_val;

  always_comb begin
    core_val = reg_mode_i ? q_i : sum_i;
    pin_o    = act_high_i ? core_val : ~core_val;
    pin_oe_o = oe_term_i;
    pad_val  = oe_term_i ? pin_o : pin_ext_i;
    fb_o     = reg_mode_i ? ~q_i : pad_val;
  end

endmodule

// File: rtl/pal_macrocell_bank.sv
module pal_macrocell_bank #(
  parameter int CELLS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CELLS-1:0] cfg_reg_mode_i,
  input  logic [CELLS-1:0] cfg_act_high_i,
  input  logic [CELLS-1:0] sum_i,
  input  logic [CELLS-1:0] oe_term_i,
  input  logic [CELLS-1:0] pin_ext_i,
  input  logic             sset_i,
  input  logic             areset_i,
  input  logic             preload_en_i,
  input  logic [CELLS-1:0] preload_val_i,
  output logic [CELLS-1:0] pin_o,
  output logic [CELLS-1:0] pin_oe_o,
  output logic [CELLS-1:0] fb_o
);

  logic             rst_sync_n;
  logic             clr_n;
  logic [CELLS-1:0] q;

  pal_mc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) rst_sync_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign clr_n = rst_sync_n & ~areset_i;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    pal_mc_cell_reg reg_i (
      .clk_i         (clk_i),
      .clr_ni        (clr_n),
      .sum_i         (sum_i[c]),
      .sset_i        (sset_i),
      .preload_en_i  (preload_en_i),
      .preload_val_i (preload_val_i[c]),
      .q_o           (q[c])
    );

    pal_mc_cell_out out_i (
      .reg_mode_i (cfg_reg_mode_i[c]),
      .act_high_i (cfg_act_high_i[c]),
      .q_i        (q[c]),
      .sum_i      (sum_i[c]),
      .oe_term_i  (oe_term_i[c]),
      .pin_ext_i  (pin_ext_i[c]),
      .pin_o      (pin_o[c]),
      .pin_oe_o   (pin_oe_o[c]),
      .fb_o       (fb_o[c])
    );
  end

endmodule

// File: rtl/pal_macrocell_bank_chk.sv
module pal_macrocell_bank_chk #(
  parameter int CELLS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_sync_n,
  input logic [CELLS-1:0] cfg_reg_mode_i,
  input logic [CELLS-1:0] cfg_act_high_i,
  input logic [CELLS-1:0] sum_i,
  input logic [CELLS-1:0] oe_term_i,
  input logic [CELLS-1:0] pin_ext_i,
  input logic             sset_i,
  input logic             areset_i,
  input logic             preload_en_i,
  input logic [CELLS-1:0] preload_val_i,
  input logic [CELLS-1:0] pin_o,
  input logic [CELLS-1:0] pin_oe_o,
  input logic [CELLS-1:0] fb_o
);

  for (genvar c = 0; c < CELLS; c++) begin : g_chk
    a_r1_powerup_level: assert property (@(posedge clk_i)
      (!rst_ni && cfg_reg_mode_i[c]) |-> (pin_o[c] == !cfg_act_high_i[c]));

    a_r2_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (!areset_i && !preload_en_i && !sset_i) |=>
        (areset_i || !$stable(cfg_reg_mode_i) || !$stable(cfg_act_high_i) ||
         !cfg_reg_mode_i[c] || (pin_o[c] == ($past(sum_i[c]) ^ !cfg_act_high_i[c]))));

    a_r4_set_level: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (sset_i && !areset_i && !preload_en_i) |=>
        (areset_i || !$stable(cfg_reg_mode_i) || !$stable(cfg_act_high_i) ||
         !cfg_reg_mode_i[c] || (pin_o[c] == cfg_act_high_i[c])));

    a_r5_clear_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (areset_i && cfg_reg_mode_i[c]) |-> (pin_o[c] == !cfg_act_high_i[c]));

    a_r6_preload_load: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (preload_en_i && !areset_i) |=>
        (areset_i || !$stable(cfg_reg_mode_i) || !$stable(cfg_act_high_i) ||
         !cfg_reg_mode_i[c] ||
         (pin_o[c] == ($past(preload_val_i[c]) ^ !cfg_act_high_i[c]))));

    a_r8_fb_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_reg_mode_i[c] |-> (fb_o[c] == (pin_o[c] ^ cfg_act_high_i[c])));

    a_r9_fb_pin_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_reg_mode_i[c] && !pin_oe_o[c]) |-> (fb_o[c] == pin_ext_i[c]));
  end

endmodule

bind pal_macrocell_bank pal_macrocell_bank_chk #(.CELLS(CELLS)) chk_i (.*);

// File: tb/pal_macrocell_bank_tb_top.sv
module pal_macrocell_bank_tb_top;

  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [N-1:0] cfg_reg_mode_i;
  logic [N-1:0] cfg_act_high_i;
  logic [N-1:0] sum_i;
  logic [N-1:0] oe_term_i;
  logic [N-1:0] pin_ext_i;
  logic         sset_i;
  logic         areset_i;
  logic         preload_en_i;
  logic [N-1:0] preload_val_i;
  logic [N-1:0] pin_o;
  logic [N-1:0] pin_oe_o;
  logic [N-1:0] fb_o;

  int    total = 0;
  int    bad   = 0;
  logic  [N-1:0] mq;
  string last_tag = "R1";
  bit    done = 0;

  always #4 clk_i = ~clk_i;

  pal_macrocell_bank #(.CELLS(N), .SYNC_STAGES(2)) dut_i (.*);

  function automatic logic exp_pin(int c);
    return (cfg_reg_mode_i[c] ? mq[c] : sum_i[c]) ^ ~cfg_act_high_i[c];
  endfunction

  function automatic logic exp_fb(int c);
    if (cfg_reg_mode_i[c]) return ~mq[c];
    return oe_term_i[c] ? exp_pin(c) : pin_ext_i[c];
  endfunction

  task automatic chk(string tag, string what, int c, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cell%0d %s got %b exp %b", tag, c, what, act, exp);
    end
  endtask

  task automatic check_all();
    for (int c = 0; c < N; c++) begin
      string tp;
      if (!rst_ni) tp = "R1";
      else if (areset_i) tp = "R5";
      else if (!cfg_reg_mode_i[c]) tp = "R3";
      else tp = last_tag;
      chk(tp, "pin", c, pin_o[c], exp_pin(c));
      chk("R7", "oe", c, pin_oe_o[c], oe_term_i[c]);
      chk(cfg_reg_mode_i[c] ? "R8" : "R9", "fb", c, fb_o[c], exp_fb(c));
    end
  endtask

  // drive mid-cycle, check, then apply the edge to the model
  task automatic cycle(logic [N-1:0] s, logic [N-1:0] oe, logic [N-1:0] ext,
                       logic set, logic clr, logic pl, logic [N-1:0] pv);
    @(negedge clk_i);
    sum_i = s; oe_term_i = oe; pin_ext_i = ext;
    sset_i = set; areset_i = clr; preload_en_i = pl; preload_val_i = pv;
    if (clr) mq = '0;
    #1 check_all();
    @(posedge clk_i);
    if (clr) begin mq = '0; last_tag = "R5"; end
    else if (pl) begin mq = pv; last_tag = "R6"; end
    else if (set) begin mq = '1; last_tag = "R4,R10"; end
    else begin mq = s; last_tag = "R2"; end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_0011);
    rst_ni = 1'b1;
    for (int c = 0; c < N; c++) begin
      cfg_reg_mode_i[c] = c[1];
      cfg_act_high_i[c] = c[0];
    end
    sum_i = '0; oe_term_i = '1; pin_ext_i = '0; sset_i = 0; areset_i = 0;
    preload_en_i = 0; preload_val_i = '0; mq = '0;
    #1 rst_ni = 1'b0;

    // R1: power-up clear with all four mode/polarity pairs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      sum_i = N'($urandom); oe_term_i = N'($urandom); pin_ext_i = N'($urandom);
      #1 check_all();
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) cycle('0, '1, '0, 0, 0, 0, '0);

    // R2 / R3 directed data patterns
    cycle('1, '1, '0, 0, 0, 0, '0);
    cycle('0, '1, '0, 0, 0, 0, '0);
    cycle(N'('b0101), '1, '0, 0, 0, 0, '0);
    cycle(N'('b1010), '1, '0, 0, 0, 0, '0);

    // R4, R10: set loads 1 in all cells despite sum 0
    cycle('0, '1, '0, 1, 0, 0, '0);
    cycle('0, '1, '0, 0, 0, 0, '0);

    // R5: clear raised mid-cycle after a set, held over an edge
    cycle('0, '1, '0, 1, 0, 0, '0);
    @(posedge clk_i);
    mq = '1;
    last_tag = "R4,R10";
    #2 areset_i = 1'b1; mq = '0;
    #1 check_all();
    @(posedge clk_i);
    #2 areset_i = 1'b0; sset_i = 1'b0;
    #1 check_all();
    @(posedge clk_i);
    mq = sum_i;
    last_tag = "R2";

    // R5 over R6 and R4
    cycle('1, '1, '0, 1, 1, 1, '1);
    // R6 over R4, then a plain edge after preload
    cycle('1, '1, '0, 1, 0, 1, '0);
    cycle('0, '1, '0, 0, 0, 1, '1);
    cycle('0, '1, '0, 0, 0, 0, '0);
    cycle('0, '1, '0, 0, 0, 0, '0);

    // R9: disabled combinational pins fed from outside
    cycle('1, '0, '1, 0, 0, 0, '0);
    cycle('1, '0, '0, 0, 0, 0, '0);

    // random mix, fixed configuration
    for (int k = 0; k < 1500; k++) begin
      cycle(N'($urandom), N'($urandom), N'($urandom),
            ($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 8) == 0,
            N'($urandom));
    end

    // random mix with occasional reconfiguration
    for (int k = 0; k < 1500; k++) begin
      if ((k % 32) == 0) begin
        @(negedge clk_i);
        cfg_reg_mode_i = N'($urandom);
        cfg_act_high_i = N'($urandom);
      end
      cycle(N'($urandom), N'($urandom), N'($urandom),
            ($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 8) == 0,
            N'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule